// File: doc/BRIEF.md
# Split Event Pattern Classifier

This block watches a stream of offset-corrected pixel values and finds photon hits in it. Every pixel arrives with its own noise sigma. A pixel well above its own noise level is a seed candidate. Pixels in the 3x3 square around a seed that clear a lower noise-scaled level are counted as part of the same hit. The block emits one record per accepted seed. The record holds the seed position, the summed amplitude of the seed and its joined neighbours, how many pixels took part, and whether the charge stayed in one pixel or was split over several.

Pixels enter in raster order, one per valid cycle. A frame-start marker comes with the first pixel of a frame and a line-start marker comes with the first pixel of each line. Column and row offsets must already be subtracted upstream. Internally, a delay line two rows plus three pixels deep gives access to every 3x3 window. For each pixel it stores the value and two precomputed threshold flags. The last row of a frame is finished on idle cycles that follow the frame.

Top module: `hit_pattern_classifier`

## Requirements
- R1: A pixel is a seed candidate when 4*value > 5*sigma, strictly. The value is two's complement and PIX_W bits wide. The sigma code is an unsigned number in quarter units (SIG_FRAC = 2 fraction bits). Zero and negative values never qualify.
- R2: A pixel joins a hit as a neighbour when 4*value > 3*sigma, strictly, using its own sigma.
- R3: Only the eight pixels directly around the seed can join. A pixel two rows or two columns away never contributes.
- R4: ev_split is 0 when no neighbour qualified (ev_count = 1) and 1 otherwise.
- R5: ev_sum is the seed value plus the values of all qualifying neighbours. ev_count is 1 plus the number of those neighbours.
- R6: Positions outside the frame count as below threshold. A pixel in the last column is never combined with the first column of the next line, and the same holds at the top and bottom rows.
- R7: When a seed candidate has another seed candidate in its 3x3 square, only the strictly larger one is reported. If the values are equal, the one earlier in raster order is reported. A suppressed candidate produces no record.
- R8: Each reported record carries the seed row (ev_row) and column (ev_col). Records leave in raster order of their seeds, exactly one per accepted seed.
- R9: pix_sof restarts the position at row 0, column 0. After the last pixel of a frame, COLS+1 cycles without pix_valid complete all remaining records. No pixel may be sent during those cycles.
- R10: While reset is held and right after it is released, ev_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | A pixel is presented this cycle |
| pix_sof | input | 1 | Pixel is the first of a frame |
| pix_sol | input | 1 | Pixel is the first of a line |
| pix_value | input | PIX_W | Offset-corrected pixel value, signed |
| pix_sigma | input | SIG_W | Noise sigma of this pixel, unsigned, quarter units |
| ev_valid | output | 1 | A hit record is presented this cycle |
| ev_row | output | $clog2(ROWS) | Seed row |
| ev_col | output | $clog2(COLS) | Seed column |
| ev_sum | output | SUM_W | Seed plus neighbour amplitude |
| ev_count | output | CNT_W | Pixels in the hit (1 to 9) |
| ev_split | output | 1 | 1 when the hit spans more than one pixel |

## Verification
Isolated hits check the single-pixel record. Hits with neighbours sitting exactly on and just above the lower level show which neighbours the sum counts and that the count comes out right. Seeds placed at frame corners and at line ends, with above-threshold pixels where a wrong row wrap would pick them up, show that edge masking works. Paired seeds with equal values and with unequal values, in both orientations, test the tie-break and the larger-wins rule, and per-pixel sigma values chosen around the seed level test the strict compare. Random sparse and dense frames with random sigmas then cover many mixed patterns against an independent model.

// File: rtl/hpc_pkg.sv
package hpc_pkg;
    parameter int unsigned PIX_W    = 12;
    parameter int unsigned SIG_W    = 8;
    parameter int unsigned SIG_FRAC = 2;
    parameter int unsigned SUM_W    = PIX_W + 3;
    parameter int unsigned CNT_W    = 4;
    parameter int unsigned CMP_W    = PIX_W + SIG_W + SIG_FRAC;

    // one stored pixel: value and its two precomputed threshold flags
    typedef struct packed {
        logic signed [PIX_W-1:0] val;
        logic                    seed;
        logic                    nbr;
    } cell_t;
endpackage

// File: rtl/hpc_qualify.sv
module hpc_qualify
    import hpc_pkg::*;
(
    input  logic [PIX_W-1:0] value_i,
    input  logic [SIG_W-1:0] sigma_i,
    output logic             seed_o,
    output logic             nbr_o
);
    logic [CMP_W-1:0] mag_l;
    logic [CMP_W-1:0] sig_l;
    logic [CMP_W-1:0] lim_hi;
    logic [CMP_W-1:0] lim_lo;

    // shift-and-add forms 5*sigma and 3*sigma; value scaled to sigma units
    always_comb begin
        mag_l  = CMP_W'(value_i[PIX_W-2:0]) << SIG_FRAC;
        sig_l  = CMP_W'(sigma_i);
        lim_hi = (sig_l << 2) + sig_l;
        lim_lo = (sig_l << 1) + sig_l;
        seed_o = !value_i[PIX_W-1] && (mag_l > lim_hi);
        nbr_o  = !value_i[PIX_W-1] && (mag_l > lim_lo);
    end
endmodule

// File: rtl/hpc_window.sv
module hpc_window
    import hpc_pkg::*;
#(
    parameter  int unsigned COLS  = 64,
    parameter  int unsigned ROWS  = 64,
    localparam int unsigned PR_W  = $clog2(ROWS + 2),
    localparam int unsigned PC_W  = $clog2(COLS),
    localparam int unsigned OR_W  = $clog2(ROWS),
    localparam int unsigned DEPTH = 2 * COLS + 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pix_valid_i,
    input  logic            sof_i,
    input  logic            sol_i,
    input  cell_t           cell_i,
    output cell_t [8:0]     win_o,
    output logic            eval_o,
    output logic [OR_W-1:0] crow_o,
    output logic [PC_W-1:0] ccol_o
);
    typedef struct packed {
        cell_t [DEPTH-1:0] line;
        logic [PR_W-1:0]   prow;
        logic [PC_W-1:0]   pcol;
        logic              flush;
        logic              eval;
        logic [PR_W-1:0]   crow;
        logic [PC_W-1:0]   ccol;
    } win_state_t;

    win_state_t st_d, st_q;
    logic       step;
    logic [PR_W-1:0] nrow;
    logic [PC_W-1:0] ncol;
    cell_t      new_cell;

    always_comb begin
        st_d     = st_q;
        step     = pix_valid_i || st_q.flush;
        nrow     = st_q.prow;
        ncol     = st_q.pcol;
        new_cell = pix_valid_i ? cell_i : cell_t'('0);
        if (pix_valid_i) begin
            if (sof_i) begin
                nrow = '0;
                ncol = '0;
            end else if (sol_i) begin
                nrow = st_q.prow + 1'b1;
                ncol = '0;
            end else begin
                ncol = st_q.pcol + 1'b1;
            end
        end else if (st_q.pcol == PC_W'(COLS - 1)) begin
            nrow = st_q.prow + 1'b1;
            ncol = '0;
        end else begin
            ncol = st_q.pcol + 1'b1;
        end

        st_d.eval = 1'b0;
        if (step) begin
            st_d.line = {st_q.line[DEPTH-2:0], new_cell};
            st_d.prow = nrow;
            st_d.pcol = ncol;
            // flush runs until virtual position (ROWS+1, 0) has been inserted
            st_d.flush = pix_valid_i
                ? (nrow == PR_W'(ROWS - 1) && ncol == PC_W'(COLS - 1))
                : (nrow != PR_W'(ROWS + 1));
            // centre lags the inserted pixel by one row and one column
            if (ncol != '0) begin
                st_d.eval = (nrow != '0);
                st_d.crow = nrow - 1'b1;
                st_d.ccol = ncol - 1'b1;
            end else begin
                st_d.eval = (nrow >= PR_W'(2));
                st_d.crow = nrow - PR_W'(2);
                st_d.ccol = PC_W'(COLS - 1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.prow  <= PR_W'(ROWS + 1);
        end else begin
            st_q <= st_d;
        end
    end

    // 3x3 taps with frame-edge masking; index = 3*row_offset + col_offset
    for (genvar dr = 0; dr < 3; dr++) begin : g_row
        for (genvar dc = 0; dc < 3; dc++) begin : g_col
            localparam int unsigned TAP = 2 * COLS + 2 - dr * COLS - dc;
            logic keep_w;
            assign keep_w = !((dr == 0) && (st_q.crow == '0))
                         && !((dr == 2) && (st_q.crow == PR_W'(ROWS - 1)))
                         && !((dc == 0) && (st_q.ccol == '0))
                         && !((dc == 2) && (st_q.ccol == PC_W'(COLS - 1)));
            assign win_o[dr*3+dc] = keep_w ? st_q.line[TAP] : cell_t'('0);
        end
    end

    assign eval_o = st_q.eval;
    assign crow_o = st_q.crow[OR_W-1:0];
    assign ccol_o = st_q.ccol;

    a_r9_quiet_flush: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.flush |-> !pix_valid_i);
    a_r6_centre_inside: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.eval |-> (st_q.crow < PR_W'(ROWS)) && (32'(st_q.ccol) < COLS));
    a_r1_seed_implies_nbr: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid_i |-> (!cell_i.seed || cell_i.nbr));
endmodule

// File: rtl/hpc_judge.sv
module hpc_judge
    import hpc_pkg::*;
#(
    parameter  int unsigned COLS = 64,
    parameter  int unsigned ROWS = 64,
    localparam int unsigned OR_W = $clog2(ROWS),
    localparam int unsigned OC_W = $clog2(COLS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eval_i,
    input  logic [OR_W-1:0]  crow_i,
    input  logic [OC_W-1:0]  ccol_i,
    input  cell_t [8:0]      win_i,
    output logic             ev_valid_o,
    output logic [OR_W-1:0]  ev_row_o,
    output logic [OC_W-1:0]  ev_col_o,
    output logic [SUM_W-1:0] ev_sum_o,
    output logic [CNT_W-1:0] ev_count_o,
    output logic             ev_split_o
);
    typedef struct packed {
        logic             valid;
        logic [OR_W-1:0]  row;
        logic [OC_W-1:0]  col;
        logic [SUM_W-1:0] sum;
        logic [CNT_W-1:0] count;
        logic             split;
    } rec_t;

    rec_t  rec_d, rec_q;
    cell_t centre;
    logic  beaten;
    logic [SUM_W-1:0] acc;
    logic [CNT_W-1:0] cnt;

    always_comb begin
        centre = win_i[4];
        beaten = 1'b0;
        acc    = SUM_W'($unsigned(centre.val));
        cnt    = CNT_W'(1);
        for (int k = 0; k < 9; k++) begin
            if (k != 4) begin
                if (win_i[k].seed) begin
                    // taps 0..3 precede the centre in raster order
                    if (k < 4) begin
                        if (!($signed(centre.val) > $signed(win_i[k].val))) beaten = 1'b1;
                    end else begin
                        if ($signed(centre.val) < $signed(win_i[k].val)) beaten = 1'b1;
                    end
                end
                if (win_i[k].nbr) begin
                    acc = acc + SUM_W'($unsigned(win_i[k].val));
                    cnt = cnt + CNT_W'(1);
                end
            end
        end
        rec_d.valid = eval_i && centre.seed && !beaten;
        rec_d.row   = crow_i;
        rec_d.col   = ccol_i;
        rec_d.sum   = acc;
        rec_d.count = cnt;
        rec_d.split = (cnt != CNT_W'(1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rec_q <= '0;
        else        rec_q <= rec_d;
    end

    assign ev_valid_o = rec_q.valid;
    assign ev_row_o   = rec_q.row;
    assign ev_col_o   = rec_q.col;
    assign ev_sum_o   = rec_q.sum;
    assign ev_count_o = rec_q.count;
    assign ev_split_o = rec_q.split;

    a_r10_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !ev_valid_o);
    a_r5_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid_o |-> (ev_count_o >= CNT_W'(1)) && (ev_count_o <= CNT_W'(9)));
    a_r8_position_inside: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid_o |-> (32'(ev_row_o) < ROWS) && (32'(ev_col_o) < COLS));
    a_r7_tie_goes_earlier: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_i && win_i[4].seed && win_i[3].seed && (win_i[3].val == win_i[4].val))
        |=> !ev_valid_o);
endmodule

// File: rtl/hit_pattern_classifier.sv
module hit_pattern_classifier
    import hpc_pkg::*;
#(
    parameter  int unsigned COLS = 64,
    parameter  int unsigned ROWS = 64,
    localparam int unsigned OR_W = $clog2(ROWS),
    localparam int unsigned OC_W = $clog2(COLS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_valid,
    input  logic             pix_sof,
    input  logic             pix_sol,
    input  logic [PIX_W-1:0] pix_value,
    input  logic [SIG_W-1:0] pix_sigma,
    output logic             ev_valid,
    output logic [OR_W-1:0]  ev_row,
    output logic [OC_W-1:0]  ev_col,
    output logic [SUM_W-1:0] ev_sum,
    output logic [CNT_W-1:0] ev_count,
    output logic             ev_split
);
    cell_t           in_cell;
    cell_t [8:0]     win;
    logic            eval;
    logic [OR_W-1:0] crow;
    logic [OC_W-1:0] ccol;
    logic            seed_f;
    logic            nbr_f;

    hpc_qualify u_qualify (
        .value_i (pix_value),
        .sigma_i (pix_sigma),
        .seed_o  (seed_f),
        .nbr_o   (nbr_f)
    );

    assign in_cell.val  = pix_value;
    assign in_cell.seed = seed_f;
    assign in_cell.nbr  = nbr_f;

    hpc_window #(.COLS(COLS), .ROWS(ROWS)) u_window (
        .clk         (clk),
        .rst_n       (rst_n),
        .pix_valid_i (pix_valid),
        .sof_i       (pix_sof),
        .sol_i       (pix_sol),
        .cell_i      (in_cell),
        .win_o       (win),
        .eval_o      (eval),
        .crow_o      (crow),
        .ccol_o      (ccol)
    );

    hpc_judge #(.COLS(COLS), .ROWS(ROWS)) u_judge (
        .clk        (clk),
        .rst_n      (rst_n),
        .eval_i     (eval),
        .crow_i     (crow),
        .ccol_i     (ccol),
        .win_i      (win),
        .ev_valid_o (ev_valid),
        .ev_row_o   (ev_row),
        .ev_col_o   (ev_col),
        .ev_sum_o   (ev_sum),
        .ev_count_o (ev_count),
        .ev_split_o (ev_split)
    );
endmodule

// File: tb/hit_pattern_classifier_bench.sv
module hit_pattern_classifier_bench;
    localparam int C = 12;
    localparam int R = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_valid = 1'b0, pix_sof = 1'b0, pix_sol = 1'b0;
    logic [11:0] pix_value = '0;
    logic [7:0]  pix_sigma = '0;
    logic        ev_valid;
    logic [2:0]  ev_row;
    logic [3:0]  ev_col;
    logic [14:0] ev_sum;
    logic [3:0]  ev_count;
    logic        ev_split;

    always #5 clk = ~clk;

    hit_pattern_classifier #(.COLS(C), .ROWS(R)) u_hit_pattern_classifier (
        .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_sof(pix_sof),
        .pix_sol(pix_sol), .pix_value(pix_value), .pix_sigma(pix_sigma),
        .ev_valid(ev_valid), .ev_row(ev_row), .ev_col(ev_col), .ev_sum(ev_sum),
        .ev_count(ev_count), .ev_split(ev_split)
    );

    typedef struct { int row; int col; int sum; int cnt; int split; } ev_t;
    ev_t got[$];
    ev_t exp_q[$];
    int  pv[R][C];
    int  sv[R][C];
    int  checks = 0, errors = 0;
    bit  done = 1'b0;

    always @(negedge clk)
        if (rst_n && ev_valid)
            got.push_back('{int'(ev_row), int'(ev_col), int'(ev_sum),
                            int'(ev_count), int'(ev_split)});

    function automatic bit inside_f(int r, int c);
        return r >= 0 && r < R && c >= 0 && c < C;
    endfunction
    function automatic bit seed_at(int r, int c);   // R1
        if (!inside_f(r, c)) return 1'b0;
        return pv[r][c] * 4 > 5 * sv[r][c];
    endfunction
    function automatic bit nbr_at(int r, int c);    // R2
        if (!inside_f(r, c)) return 1'b0;
        return pv[r][c] * 4 > 3 * sv[r][c];
    endfunction

    task automatic build_expected();
        exp_q.delete();
        for (int r = 0; r < R; r++)
            for (int c = 0; c < C; c++) begin
                bit lose = 1'b0;
                int s = pv[r][c];
                int n = 1;
                if (!seed_at(r, c)) continue;
                for (int dr = -1; dr <= 1; dr++)
                    for (int dc = -1; dc <= 1; dc++) begin
                        if (dr == 0 && dc == 0) continue;
                        if (seed_at(r+dr, c+dc)) begin
                            if (dr < 0 || (dr == 0 && dc < 0)) begin
                                if (!(pv[r][c] > pv[r+dr][c+dc])) lose = 1'b1;
                            end else if (pv[r+dr][c+dc] > pv[r][c]) lose = 1'b1;
                        end
                        if (nbr_at(r+dr, c+dc)) begin
                            s += pv[r+dr][c+dc];
                            n++;
                        end
                    end
                if (!lose) exp_q.push_back('{r, c, s, n, int'(n != 1)});
            end
    endtask

    task automatic clear_frame(int sig);
        for (int r = 0; r < R; r++)
            for (int c = 0; c < C; c++) begin
                pv[r][c] = 0;
                sv[r][c] = sig;
            end
    endtask

    task automatic send_frame();
        for (int r = 0; r < R; r++)
            for (int c = 0; c < C; c++) begin
                @(negedge clk);
                pix_valid = 1'b1;
                pix_sof   = (r == 0 && c == 0);
                pix_sol   = (c == 0);
                pix_value = 12'(pv[r][c]);
                pix_sigma = 8'(sv[r][c]);
            end
        @(negedge clk);
        pix_valid = 1'b0; pix_sof = 1'b0; pix_sol = 1'b0;
        repeat (C + 6) @(negedge clk);
    endtask

    task automatic run_frame(string tag);
        build_expected();
        send_frame();
        checks++;
        if (got.size() != exp_q.size()) begin
            errors++;
            $display("FAIL %s record count: got %0d expected %0d", tag, got.size(), exp_q.size());
        end
        for (int i = 0; i < exp_q.size() && i < got.size(); i++) begin
            checks++;
            if (got[i] != exp_q[i]) begin
                errors++;
                $display("FAIL %s record %0d: got r%0d c%0d sum %0d cnt %0d split %0d expected r%0d c%0d sum %0d cnt %0d split %0d",
                         tag, i, got[i].row, got[i].col, got[i].sum, got[i].cnt, got[i].split,
                         exp_q[i].row, exp_q[i].col, exp_q[i].sum, exp_q[i].cnt, exp_q[i].split);
            end
        end
        got.delete();
    endtask

    task automatic random_frame(int pct);
        for (int r = 0; r < R; r++)
            for (int c = 0; c < C; c++) begin
                sv[r][c] = int'($urandom_range(4, 40));
                if (int'($urandom_range(0, 99)) < pct) pv[r][c] = int'($urandom_range(20, 700));
                else pv[r][c] = int'($urandom_range(0, 40)) - 20;
            end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        checks++;   // R10 during reset
        if (ev_valid !== 1'b0) begin errors++; $display("FAIL R10 in reset: got %b expected 0", ev_valid); end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        checks++;   // R10 after release
        if (ev_valid !== 1'b0) begin errors++; $display("FAIL R10 after reset: got %b expected 0", ev_valid); end

        // sigma code 8 = 2.0: seed above 10, neighbour above 6
        clear_frame(8); pv[3][5] = 50;
        run_frame("R4 single");

        clear_frame(8); pv[3][5] = 50; pv[3][6] = 7; pv[4][4] = 20; pv[2][5] = 6;
        run_frame("R5 R2 split");

        clear_frame(8); pv[1][2] = 10; pv[1][8] = 11; pv[5][2] = 12; sv[5][2] = 9;
        pv[5][6] = 11; sv[5][6] = 9; pv[3][9] = -100;
        run_frame("R1 boundary");

        clear_frame(8); pv[4][4] = 30; pv[4][5] = 30; pv[1][1] = 20; pv[2][2] = 40;
        pv[6][9] = 30; pv[5][10] = 30;
        run_frame("R7 competing");

        clear_frame(8); pv[0][0] = 40; pv[1][1] = 8; pv[R-1][C-1] = 40; pv[R-2][C-2] = 9;
        pv[2][C-1] = 40; pv[3][0] = 30; pv[5][0] = 25; pv[4][C-1] = 9;
        run_frame("R6 R9 edges");

        clear_frame(8); pv[4][5] = 40; pv[4][7] = 9; pv[6][5] = 9; pv[2][3] = 9;
        run_frame("R3 reach");

        for (int f = 0; f < 4; f++) begin
            random_frame(6);
            run_frame("R8 random sparse");
        end
        for (int f = 0; f < 3; f++) begin
            random_frame(35);
            run_frame("R8 R7 random dense");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule